// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps three tables of 2-bit saturating counters. The first is a per-address (bimodal) table. The second is a two-level table indexed through a global outcome history. The third is a chooser table that decides, for each branch, which of the other two to trust. A lookup presents the fall-through address of the branch, which is the address of the instruction that follows it. In the same cycle the block returns a taken/not-taken guess and a checkpoint. The checkpoint holds the three table indices and the vote of each component.

When the branch resolves, the front end hands the checkpoint back together with the fall-through address and the resolved target. The block then trains both component counters, trains the chooser only if the two components disagreed, and shifts the outcome into the global history. All table sizes are parameters. A mode parameter selects how history and address are combined for the two-level index.

Top module: `tourn_pred`

## Requirements
- R1: Every counter is 2 bits wide. An update never moves it above 3 or below 0. A value of 2 or 3 is a taken vote, and 0 or 1 is a not-taken vote.
- R2: Synchronous reset loads counter entry i of each table with 1 + (i mod 2): even entries hold 1 and odd entries hold 2. Reset also clears the history register to 0.
- R3: The bimodal index and the chooser index are each the low log2(size) bits of (addr XOR (addr >> 16)).
- R4: With HIST_XOR=1 (the default), the two-level index is the low log2(size) bits of (history XOR addr). With HIST_XOR=0, it is the low bits of (history OR (addr << history width)).
- R5: The prediction `lk_taken` takes the two-level vote when the selected chooser counter is 2 or more, and the bimodal vote otherwise. It is combinational in the lookup cycle.
- R6: The history register is log2(two-level size) bits wide. Each update shifts it left by one, puts the outcome in bit 0 and drops the top bit.
- R7: On every update, the bimodal and two-level counters named by the checkpoint both move one step toward the outcome, whichever component was chosen.
- R8: The chooser counter changes only when the checkpoint's two votes differ. It steps up when the two-level vote equalled the outcome and steps down otherwise.
- R9: The outcome is taken when `up_target` differs from `up_fall_addr`, and not taken when they are equal.
- R10: Updates write at the indices carried in the checkpoint. A lookup in the same cycle as an update to the same entry sees the value from before the update. The new value is visible from the next cycle on.
- R11: The checkpoint outputs carry the three indices and the two component votes computed for the current lookup address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | ADDR_W | Fall-through address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_bim_idx | output | log2(BIM_ENT) | Checkpoint: bimodal index |
| lk_gsh_idx | output | log2(GSH_ENT) | Checkpoint: two-level index |
| lk_meta_idx | output | log2(META_ENT) | Checkpoint: chooser index |
| lk_bim_vote | output | 1 | Checkpoint: bimodal vote |
| lk_gsh_vote | output | 1 | Checkpoint: two-level vote |
| up_valid | input | 1 | Apply a training update this cycle |
| up_bim_idx | input | log2(BIM_ENT) | Returned checkpoint: bimodal index |
| up_gsh_idx | input | log2(GSH_ENT) | Returned checkpoint: two-level index |
| up_meta_idx | input | log2(META_ENT) | Returned checkpoint: chooser index |
| up_bim_vote | input | 1 | Returned checkpoint: bimodal vote |
| up_gsh_vote | input | 1 | Returned checkpoint: two-level vote |
| up_fall_addr | input | ADDR_W | Fall-through address of the resolved branch |
| up_target | input | ADDR_W | Resolved destination of the branch |

## Verification
The hardest case to reach from the ports is a lookup that reads a counter in the same cycle that an update writes it. The chooser state is equally hard to observe, because it shows only in which vote the prediction follows. The bench always overlaps each update with the next lookup, so every repeated branch collides with its own training. It also uses one directed branch at a fresh entry to check that the colliding lookup sees the old value. Chooser training is driven by a repeating loop pattern, which only the history-indexed table can learn, and by a strongly biased branch, which favours the bimodal table. A random stream over a small set of addresses then forces frequent disagreements between the two components. The bench's model checks every prediction and checkpoint against those events.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_TOP = 2'd3;
    localparam ctr2_t CTR_BOT = 2'd0;

    // One saturating step toward the given direction
    function automatic ctr2_t ctr_step(ctr2_t c, logic up);
        if (up)
            return (c == CTR_TOP) ? CTR_TOP : c + 2'd1;
        else
            return (c == CTR_BOT) ? CTR_BOT : c - 2'd1;
    endfunction

    function automatic logic ctr_vote(ctr2_t c);
        return c >= 2'd2;
    endfunction

    // Reset image: alternating weak states
    function automatic ctr2_t ctr_init(int i);
        return (i % 2 == 1) ? 2'd2 : 2'd1;
    endfunction

    // Fold the upper half-word onto the address
    function automatic logic [63:0] addr_fold(logic [63:0] a);
        return a ^ (a >> 16);
    endfunction

endpackage

// File: rtl/ctr_table.sv
module ctr_table
    import tourn_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    ctr2_t tbl [ENTRIES];

    assign rd_val = tbl[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                tbl[i] <= ctr_init(i);
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_up);
        end
    end

    // R1: saturation at both ends
    a_r1_sat_top: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_up && tbl[wr_idx] == 2'd3) |=> tbl[$past(wr_idx)] == 2'd3);
    a_r1_sat_bottom: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_up && tbl[wr_idx] == 2'd0) |=> tbl[$past(wr_idx)] == 2'd0);
    // R7: an unsaturated taken write moves exactly one step
    a_r7_one_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_up && tbl[wr_idx] != 2'd3)
        |=> tbl[$past(wr_idx)] == $past(tbl[wr_idx]) + 2'd1);
    // R2: an odd entry comes out of reset weakly taken
    a_r2_reset_image: assert property (@(posedge clk)
        rst |=> tbl[1] == 2'd2);

endmodule

// File: rtl/ghist_reg.sv
module ghist_reg #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [HW-1:0] hist
);

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (shift_en)
            hist <= {hist[HW-2:0], bit_in};
    end

    // R6: outcome enters at bit 0, older bits move up
    a_r6_shift_in: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (hist[0] == $past(bit_in)) && (hist[HW-1:1] == $past(hist[HW-2:0])));
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist));

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
    import tourn_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BIM_ENT  = 256,
    parameter int GSH_ENT  = 256,
    parameter int META_ENT = 256,
    parameter bit HIST_XOR = 1'b1,
    localparam int BIM_W   = $clog2(BIM_ENT),
    localparam int GSH_W   = $clog2(GSH_ENT),
    localparam int META_W  = $clog2(META_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_taken,
    output logic [BIM_W-1:0]  lk_bim_idx,
    output logic [GSH_W-1:0]  lk_gsh_idx,
    output logic [META_W-1:0] lk_meta_idx,
    output logic              lk_bim_vote,
    output logic              lk_gsh_vote,
    input  logic              up_valid,
    input  logic [BIM_W-1:0]  up_bim_idx,
    input  logic [GSH_W-1:0]  up_gsh_idx,
    input  logic [META_W-1:0] up_meta_idx,
    input  logic              up_bim_vote,
    input  logic              up_gsh_vote,
    input  logic [ADDR_W-1:0] up_fall_addr,
    input  logic [ADDR_W-1:0] up_target
);

    localparam int HIST_W = GSH_W;

    typedef struct packed {
        logic [BIM_W-1:0]  bim;
        logic [GSH_W-1:0]  gsh;
        logic [META_W-1:0] meta;
        logic              bv;
        logic              gv;
    } ckpt_t;

    ckpt_t             lk_ck, up_ck;
    logic [HIST_W-1:0] hist;
    logic [63:0]       folded, hist_ext, addr_ext;
    ctr2_t             bim_val, gsh_val, meta_val;
    logic              up_taken;
    logic              meta_wr;

    // Lookup index formation
    assign addr_ext = 64'(lk_addr);
    assign hist_ext = 64'(hist);
    assign folded   = addr_fold(addr_ext);

    assign lk_ck.bim  = folded[BIM_W-1:0];
    assign lk_ck.meta = folded[META_W-1:0];

    generate
        if (HIST_XOR) begin : g_xor_idx
            logic [63:0] mix;
            assign mix = hist_ext ^ addr_ext;
            assign lk_ck.gsh = mix[GSH_W-1:0];
        end else begin : g_cat_idx
            logic [63:0] mix;
            assign mix = hist_ext | (addr_ext << HIST_W);
            assign lk_ck.gsh = mix[GSH_W-1:0];
        end
    endgenerate

    // Counter tables
    ctr_table #(.ENTRIES(BIM_ENT)) u_bim (
        .clk(clk), .rst(rst), .rd_idx(lk_ck.bim), .rd_val(bim_val),
        .wr_en(up_valid), .wr_idx(up_ck.bim), .wr_up(up_taken));

    ctr_table #(.ENTRIES(GSH_ENT)) u_gsh (
        .clk(clk), .rst(rst), .rd_idx(lk_ck.gsh), .rd_val(gsh_val),
        .wr_en(up_valid), .wr_idx(up_ck.gsh), .wr_up(up_taken));

    ctr_table #(.ENTRIES(META_ENT)) u_meta (
        .clk(clk), .rst(rst), .rd_idx(lk_ck.meta), .rd_val(meta_val),
        .wr_en(meta_wr), .wr_idx(up_ck.meta), .wr_up(up_ck.gv == up_taken));

    ghist_reg #(.HW(HIST_W)) u_hist (
        .clk(clk), .rst(rst), .shift_en(up_valid), .bit_in(up_taken), .hist(hist));

    // Votes and choice
    assign lk_ck.bv = ctr_vote(bim_val);
    assign lk_ck.gv = ctr_vote(gsh_val);
    assign lk_taken = ctr_vote(meta_val) ? lk_ck.gv : lk_ck.bv;

    assign lk_bim_idx  = lk_ck.bim;
    assign lk_gsh_idx  = lk_ck.gsh;
    assign lk_meta_idx = lk_ck.meta;
    assign lk_bim_vote = lk_ck.bv;
    assign lk_gsh_vote = lk_ck.gv;

    // Update side
    assign up_ck    = '{bim: up_bim_idx, gsh: up_gsh_idx, meta: up_meta_idx,
                        bv: up_bim_vote, gv: up_gsh_vote};
    assign up_taken = (up_target != up_fall_addr);
    assign meta_wr  = up_valid && (up_ck.bv != up_ck.gv);

    // R8: agreeing votes leave the chooser entry untouched
    a_r8_meta_hold: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_bim_vote == up_gsh_vote)
        |=> u_meta.tbl[$past(up_meta_idx)] == $past(u_meta.tbl[up_meta_idx]));
    // R9: equal target and fall-through trains toward not taken
    a_r9_not_taken: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_target == up_fall_addr) |=> hist[0] == 1'b0);
    a_r9_taken: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_target != up_fall_addr) |=> hist[0] == 1'b1);

endmodule

// File: tb/sim_tourn_pred.sv
module sim_tourn_pred;

    localparam int N  = 256;
    localparam int HM = 255;

    typedef struct {
        int          b, g, m;
        bit          bv, gv;
        logic [31:0] fall, tgt;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_addr;
    logic        lk_taken;
    logic [7:0]  lk_bim_idx, lk_gsh_idx, lk_meta_idx;
    logic        lk_bim_vote, lk_gsh_vote;
    logic        up_valid;
    logic [7:0]  up_bim_idx, up_gsh_idx, up_meta_idx;
    logic        up_bim_vote, up_gsh_vote;
    logic [31:0] up_fall_addr, up_target;

    tourn_pred u0 (
        .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_taken(lk_taken),
        .lk_bim_idx(lk_bim_idx), .lk_gsh_idx(lk_gsh_idx), .lk_meta_idx(lk_meta_idx),
        .lk_bim_vote(lk_bim_vote), .lk_gsh_vote(lk_gsh_vote),
        .up_valid(up_valid), .up_bim_idx(up_bim_idx), .up_gsh_idx(up_gsh_idx),
        .up_meta_idx(up_meta_idx), .up_bim_vote(up_bim_vote), .up_gsh_vote(up_gsh_vote),
        .up_fall_addr(up_fall_addr), .up_target(up_target));

    always #10 clk = ~clk;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;
    int   cyc_cnt  = 0;

    // behavioural model state
    int   m_bim [N];
    int   m_gsh [N];
    int   m_meta[N];
    int   m_hist;

    ent_t pend;
    bit   pend_v;
    ent_t last;
    bit   a_pred, a_bv, a_gv;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int sat(int c, bit up);
        if (up) return (c >= 3) ? 3 : c + 1;
        return (c <= 0) ? 0 : c - 1;
    endfunction

    function automatic int fold_idx(logic [31:0] a);
        return int'((a ^ (a >> 16)) & 32'hFF);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_bim[i]  = 1 + (i % 2);
            m_gsh[i]  = 1 + (i % 2);
            m_meta[i] = 1 + (i % 2);
        end
        m_hist = 0;
    endtask

    // one cycle: lookup la, optional update of u; compares outputs, advances model
    task automatic cyc(input logic [31:0] la, input bit uv, input ent_t u, output ent_t lk);
        bit exp_pred, tk;
        @(negedge clk);
        lk_addr      = la;
        up_valid     = uv;
        up_bim_idx   = 8'(u.b);
        up_gsh_idx   = 8'(u.g);
        up_meta_idx  = 8'(u.m);
        up_bim_vote  = u.bv;
        up_gsh_vote  = u.gv;
        up_fall_addr = u.fall;
        up_target    = u.tgt;
        #2;
        lk.b    = fold_idx(la);
        lk.m    = fold_idx(la);
        lk.g    = int'((la ^ 32'(m_hist)) & 32'hFF);
        lk.bv   = m_bim[lk.b] >= 2;
        lk.gv   = m_gsh[lk.g] >= 2;
        lk.fall = la;
        lk.tgt  = la;
        exp_pred = (m_meta[lk.m] >= 2) ? lk.gv : lk.bv;
        check("R3 bimodal index", int'(lk_bim_idx), lk.b);
        check("R3 chooser index", int'(lk_meta_idx), lk.m);
        check("R4 R6 two-level index", int'(lk_gsh_idx), lk.g);
        check("R11 R7 bimodal vote", int'(lk_bim_vote), int'(lk.bv));
        check("R11 R7 two-level vote", int'(lk_gsh_vote), int'(lk.gv));
        check("R5 R8 prediction", int'(lk_taken), int'(exp_pred));
        a_pred = lk_taken;
        a_bv   = lk_bim_vote;
        a_gv   = lk_gsh_vote;
        if (uv) begin
            tk = (u.tgt != u.fall);
            m_bim[u.b] = sat(m_bim[u.b], tk);
            m_gsh[u.g] = sat(m_gsh[u.g], tk);
            if (u.bv != u.gv) m_meta[u.m] = sat(m_meta[u.m], u.gv == tk);
            m_hist = ((m_hist << 1) | int'(tk)) & HM;
        end
    endtask

    // lookup a branch now, train it in the next cycle
    task automatic br(input logic [31:0] a, input bit taken);
        ent_t lk;
        cyc(a, pend_v, pend, lk);
        lk.tgt = taken ? a + 32'h100 : a;
        pend   = lk;
        pend_v = 1;
        last   = lk;
    endtask

    task automatic flush();
        ent_t lk;
        cyc(32'h0, pend_v, pend, lk);
        pend_v = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc_cnt);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        lk_addr = '0; up_valid = 0; up_bim_idx = '0; up_gsh_idx = '0; up_meta_idx = '0;
        up_bim_vote = 0; up_gsh_vote = 0; up_fall_addr = '0; up_target = '0;
        pend_v = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset image seen through the ports
        br(32'h0, 1'b0);
        check("R2 even entry bimodal vote", int'(a_bv), 0);
        check("R2 even entry two-level vote", int'(a_gv), 0);
        check("R2 even chooser picks bimodal", int'(a_pred), 0);
        br(32'h1, 1'b1);
        check("R2 odd entry bimodal vote", int'(a_bv), 1);
        check("R5 odd chooser picks two-level", int'(a_pred), 1);
        flush();

        // R10: same-cycle collision at a fresh even entry (counter 1)
        br(32'h40, 1'b1);
        br(32'h40, 1'b1);
        check("R10 lookup sees pre-update value", int'(a_bv), 0);
        flush();
        br(32'h40, 1'b1);
        check("R10 new value visible next cycle", int'(a_bv), 1);
        flush();

        // R1 R9: saturation at the top, then one not-taken step (target == fall)
        repeat (6) br(32'h77, 1'b1);
        br(32'h77, 1'b0);
        flush();
        br(32'h77, 1'b0);
        check("R1 top saturation then one step down", int'(a_bv), 1);
        repeat (6) br(32'h77, 1'b0);
        flush();
        br(32'h77, 1'b1);
        check("R9 equal target trains not taken", int'(a_bv), 0);
        flush();
        br(32'h77, 1'b0);
        check("R1 bottom saturation then one step up", int'(a_bv), 0);
        flush();

        // biased branch: bimodal learns it
        repeat (20) br(32'h9000, 1'b1);
        flush();
        br(32'h9000, 1'b1);
        check("R7 biased branch bimodal vote", int'(a_bv), 1);
        flush();

        // loop pattern T T T N: history-indexed table learns it
        for (int k = 0; k < 300; k++) begin
            br(32'h500, (k % 4) != 3);
        end
        flush();

        // random stream over a small address set
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a;
            int          sel;
            bit          t;
            sel = int'($urandom_range(0, 15));
            a   = 32'h1000 + 32'(sel * 4) + ((sel % 3 == 0) ? 32'h0003_0000 : 32'h0);
            if (sel < 4)       t = 1'b1;
            else if (sel < 8)  t = ($urandom_range(0, 9) != 0);
            else               t = $urandom_range(0, 1) == 1;
            br(a, t);
        end
        flush();

        finish_run();
    end

endmodule